// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit half of an I2C master. It is used once a START condition is already on the bus. A single write to its buffer launches the transfer of one byte. That byte may be plain data, a 7-bit address, or either half of a 10-bit address. The block clocks the byte out most-significant bit first. It then lets go of SDA for a ninth clock so the addressed slave can acknowledge, and records what the slave answered.

The SCL timing comes from a countdown baud-rate generator. The generator reloads from a programmable value, and every SCL low phase and every SCL high phase lasts one reload period. When the ninth clock ends, the generator parks with SCL held low and raises a completion flag. Nothing more happens on the bus until the CPU supplies the next byte. A write that arrives while a byte is still in flight is refused and recorded in a sticky collision flag. It is not queued.

Both bus lines are open-drain. The block only ever asserts a pull-low enable for each line, and it reads SDA back to capture the acknowledge.

Top module: `i2c_byte_tx`

## Requirements
- R1: A synchronous reset (`rst` high) leaves SCL and SDA released (`sclOe`=0, `sdaOe`=0) and clears `bufFull`, `wcol`, `ackStat` and `doneIrq`.
- R2: A `wrStrobe` sampled while no byte is in flight copies `wrData` into the buffer. On that same clock edge it sets `bufFull` and pulls SCL low (`sclOe`=1).
- R3: Each SCL low phase and each SCL high phase lasts `reload`+1 clock cycles, with `reload` at least 1. A byte produces exactly nine SCL high pulses.
- R4: Data bits go out most-significant first, with `sdaOe` = inverse of the bit (1 pulls SDA low). SDA changes exactly one cycle after each SCL falling edge and stays constant while SCL is high.
- R5: The eighth SCL falling edge clears `bufFull`. One cycle later SDA is released (`sdaOe`=0) for the acknowledge bit.
- R6: The ninth SCL falling edge loads `ackStat` with the level of `sdaIn` in the cycle just before that edge: 0 means acknowledged, 1 means not acknowledged.
- R7: The ninth SCL falling edge sets `doneIrq`. From then on, SCL stays pulled low and SDA stays released until the next accepted write.
- R8: A `wrStrobe` sampled from the accepting edge up to the ninth SCL falling edge is rejected. The buffer keeps its value, `wcol` is set, and the byte in flight is sent unaltered.
- R9: `wcol` is cleared only by `wcolClr`. The block never clears it on its own, and a collision in the same cycle as `wcolClr` wins.
- R10: `irqClr` clears `doneIrq` (write-one-to-clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrStrobe | input | 1 | Buffer write strobe from the CPU |
| wrData | input | DATA_W | Byte to transmit |
| wcolClr | input | 1 | Clears the write-collision flag |
| irqClr | input | 1 | Clears the completion flag |
| reload | input | BRG_W | Baud-rate generator reload value (SCL phase = reload+1 cycles) |
| sdaIn | input | 1 | SDA line level read back from the bus |
| sclOe | output | 1 | Pulls SCL low when 1 |
| sdaOe | output | 1 | Pulls SDA low when 1 |
| bufData | output | DATA_W | Current buffer contents |
| bufFull | output | 1 | Buffer-full flag |
| wcol | output | 1 | Write-collision flag |
| ackStat | output | 1 | Acknowledge status of the last byte (1 = no acknowledge) |
| doneIrq | output | 1 | Byte-complete interrupt flag |

## Verification
Count cycles from the negative edge that follows the accepting clock edge, and let P be reload+1. SCL is expected low in cycles 0..P-1, high in P..2P-1, and so on for nine pulses. It is then expected low for good from cycle 18P onward. The value of SDA for bit b appears in cycle 2bP+1, one cycle after the falling edge. `bufFull` must still be 1 in cycle 16P-1 and 0 in cycle 16P. `doneIrq` and `ackStat` must stay unchanged through cycle 18P-1 and take their new values in cycle 18P. The bench samples every cycle of the transfer on the negative clock edge and compares each level with these expected values, so a result that arrives one cycle early or late fails the check.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HALT
  } txState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadByte;    // accepted CPU write
    logic driveBit;    // present next data bit on SDA
    logic releaseSda;  // let go of SDA for the acknowledge slot
    logic clearFull;   // eighth falling edge
    logic sampleAck;   // ninth falling edge
  } txCtl_t;

endpackage

// File: rtl/i2c_tx_ctrl.sv
module i2c_tx_ctrl
  import i2c_tx_pkg::*;
#(
  parameter int BRG_W = 8,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrStrobe,
  input  logic [BRG_W-1:0] reload,
  output txCtl_t           ctl,
  output logic             busy,
  output logic             sclOe
);

  localparam int IDX_W = $clog2(BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(BITS - 1);

  txState_t         state;
  logic [BRG_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             firstLow;
  logic             sclOeQ;
  logic             brgZero;

  assign brgZero = (cnt == '0);
  assign busy    = (state == ST_LOW) || (state == ST_HIGH);
  assign sclOe   = sclOeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      firstLow <= 1'b0;
      sclOeQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_HALT: begin
          if (wrStrobe) begin
            state    <= ST_LOW;
            cnt      <= reload;
            bitIdx   <= '0;
            firstLow <= 1'b1;
            sclOeQ   <= 1'b1;
          end
        end
        ST_LOW: begin
          firstLow <= 1'b0;
          if (brgZero) begin
            state  <= ST_HIGH;
            cnt    <= reload;
            sclOeQ <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (brgZero) begin
            sclOeQ <= 1'b1;
            cnt    <= reload;
            if (bitIdx == LAST_IDX) begin
              state <= ST_HALT;
            end else begin
              state    <= ST_LOW;
              bitIdx   <= bitIdx + 1'b1;
              firstLow <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.loadByte   = wrStrobe && !busy;
    ctl.driveBit   = (state == ST_LOW) && firstLow && (bitIdx != LAST_IDX);
    ctl.releaseSda = (state == ST_LOW) && firstLow && (bitIdx == LAST_IDX);
    ctl.clearFull  = (state == ST_HIGH) && brgZero && (bitIdx == PRE_IDX);
    ctl.sampleAck  = (state == ST_HIGH) && brgZero && (bitIdx == LAST_IDX);
  end

endmodule

// File: rtl/i2c_tx_data.sv
module i2c_tx_data
  import i2c_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txCtl_t            ctl,
  input  logic              wrStrobe,
  input  logic              busy,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdaIn,
  input  logic              wcolClr,
  input  logic              irqClr,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              wcol,
  output logic              ackStat,
  output logic              doneIrq,
  output logic              sdaOe
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bufData  <= '0;
      sdaOe    <= 1'b0;
    end else begin
      if (ctl.loadByte) begin
        shiftReg <= wrData;
        bufData  <= wrData;
      end else if (ctl.driveBit) begin
        sdaOe    <= ~shiftReg[DATA_W-1];
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end else if (ctl.releaseSda) begin
        sdaOe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufFull <= 1'b0;
      wcol    <= 1'b0;
      ackStat <= 1'b0;
      doneIrq <= 1'b0;
    end else begin
      if (ctl.loadByte)       bufFull <= 1'b1;
      else if (ctl.clearFull) bufFull <= 1'b0;

      if (wrStrobe && busy) wcol <= 1'b1;
      else if (wcolClr)     wcol <= 1'b0;

      if (ctl.sampleAck) ackStat <= sdaIn;

      if (ctl.sampleAck) doneIrq <= 1'b1;
      else if (irqClr)   doneIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx
  import i2c_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BRG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wcolClr,
  input  logic              irqClr,
  input  logic [BRG_W-1:0]  reload,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              wcol,
  output logic              ackStat,
  output logic              doneIrq
);

  txCtl_t ctl;
  logic   busy;

  i2c_tx_ctrl #(.BRG_W(BRG_W), .BITS(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrStrobe (wrStrobe),
    .reload   (reload),
    .ctl      (ctl),
    .busy     (busy),
    .sclOe    (sclOe)
  );

  i2c_tx_data #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .wrStrobe (wrStrobe),
    .busy     (busy),
    .wrData   (wrData),
    .sdaIn    (sdaIn),
    .wcolClr  (wcolClr),
    .irqClr   (irqClr),
    .bufData  (bufData),
    .bufFull  (bufFull),
    .wcol     (wcol),
    .ackStat  (ackStat),
    .doneIrq  (doneIrq),
    .sdaOe    (sdaOe)
  );

endmodule

// File: rtl/i2c_byte_tx_chk.sv
module i2c_byte_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wrStrobe,
  input logic [DATA_W-1:0] wrData,
  input logic              busy,
  input logic              wcolClr,
  input logic              irqClr,
  input logic              sdaIn,
  input logic              sclOe,
  input logic              sdaOe,
  input logic [DATA_W-1:0] bufData,
  input logic              bufFull,
  input logic              wcol,
  input logic              ackStat,
  input logic              doneIrq
);

  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && !busy) |=> (bufFull && sclOe && bufData == $past(wrData))); // R2

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!sclOe && !$past(sclOe)) |-> $stable(sdaOe)); // R4

  AST_ACK_SLOT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    $fell(bufFull) |=> !sdaOe); // R5

  AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $rose(doneIrq) |-> (ackStat == $past(sdaIn))); // R6

  AST_HALT_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(doneIrq) |-> (sclOe && !bufFull && !sdaOe)); // R7

  AST_REJECT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && busy) |=> (wcol && $stable(bufData))); // R8

  AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wcol && !wcolClr) |=> wcol); // R9

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irqClr && !busy) |=> !doneIrq); // R10

endmodule

bind i2c_byte_tx i2c_byte_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wrStrobe (wrStrobe),
  .wrData   (wrData),
  .busy     (busy),
  .wcolClr  (wcolClr),
  .irqClr   (irqClr),
  .sdaIn    (sdaIn),
  .sclOe    (sclOe),
  .sdaOe    (sdaOe),
  .bufData  (bufData),
  .bufFull  (bufFull),
  .wcol     (wcol),
  .ackStat  (ackStat),
  .doneIrq  (doneIrq)
);

// File: tb/sim_i2c_byte_tx.sv
`timescale 1ns/1ps
module sim_i2c_byte_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       wcolClr = 1'b0;
  logic       irqClr = 1'b0;
  logic [7:0] reload = 8'd3;
  logic       slaveLow = 1'b0;
  logic       sdaIn;
  logic       sclOe, sdaOe, bufFull, wcol, ackStat, doneIrq;
  logic [7:0] bufData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // open-drain bus: either side may pull SDA low
  assign sdaIn = !(sdaOe || slaveLow);

  i2c_byte_tx u0 (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrData(wrData),
    .wcolClr(wcolClr), .irqClr(irqClr), .reload(reload), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .bufData(bufData), .bufFull(bufFull),
    .wcol(wcol), .ackStat(ackStat), .doneIrq(doneIrq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(sclOe == 1'b0,   "R1 sclOe",   sclOe, 0);
    check(sdaOe == 1'b0,   "R1 sdaOe",   sdaOe, 0);
    check(bufFull == 1'b0, "R1 bufFull", bufFull, 0);
    check(wcol == 1'b0,    "R1 wcol",    wcol, 0);
    check(doneIrq == 1'b0, "R1 doneIrq", doneIrq, 0);
    check(ackStat == 1'b0, "R1 ackStat", ackStat, 0);
  endtask

  // one byte with per-cycle waveform comparison; optional colliding write
  task automatic sendByte(input logic [7:0] data, input int rl, input bit nack,
                          input bit collide);
    int p;
    int sclErr;
    int sdaErr;
    logic sdaPrev;
    logic expScl;
    logic expSda;
    p = rl + 1;
    sclErr = 0;
    sdaErr = 0;
    @(negedge clk);
    reload   = rl[7:0];
    sdaPrev  = sdaOe;
    wrStrobe = 1'b1;
    wrData   = data;
    @(negedge clk);
    wrStrobe = 1'b0;
    for (int k = 0; k <= 20 * p; k++) begin
      slaveLow = !nack && (k >= 16 * p + 1) && (k <= 18 * p - 1);
      if (k < 18 * p) expScl = ((k / p) % 2) == 0;
      else            expScl = 1'b1;
      if (k == 0) expSda = sdaPrev;
      else if ((k - 1) / (2 * p) < 8) expSda = ~data[7 - (k - 1) / (2 * p)];
      else expSda = 1'b0;
      if (sclOe !== expScl) sclErr++;
      if (sdaOe !== expSda) sdaErr++;
      if (k == 0) begin
        check(bufFull == 1'b1, "R2 bufFull set by write", bufFull, 1);
        check(bufData == data, "R2 buffer loaded", bufData, data);
      end
      if (k == 16 * p - 1) check(bufFull == 1'b1, "R5 bufFull before 8th fall", bufFull, 1);
      if (k == 16 * p)     check(bufFull == 1'b0, "R5 bufFull cleared", bufFull, 0);
      if (k == 18 * p - 1) check(doneIrq == 1'b0, "R7 doneIrq early", doneIrq, 0);
      if (k == 18 * p) begin
        check(doneIrq == 1'b1, "R7 doneIrq set", doneIrq, 1);
        check(ackStat == nack, "R6 ackStat", ackStat, nack);
      end
      if (collide && k == 5 * p) begin
        wrStrobe = 1'b1;
        wrData   = ~data;
      end
      if (collide && k == 5 * p + 1) wrStrobe = 1'b0;
      @(negedge clk);
    end
    slaveLow = 1'b0;
    check(sclErr == 0, "R3 SCL phase timing / R7 halt", sclErr, 0);
    check(sdaErr == 0, "R4 SDA bits / R5 release", sdaErr, 0);
    if (collide) begin
      check(wcol == 1'b1, "R8 wcol set", wcol, 1);
      check(bufData == data, "R8 buffer unchanged", bufData, data);
    end
  endtask

  task automatic testIrqClear();
    @(negedge clk);
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    check(doneIrq == 1'b0, "R10 doneIrq cleared", doneIrq, 0);
    check(sclOe == 1'b1,   "R7 SCL still held low", sclOe, 1);
  endtask

  task automatic testWcolSticky();
    check(wcol == 1'b1, "R9 wcol survives later byte", wcol, 1);
    @(negedge clk);
    wcolClr = 1'b1;
    @(negedge clk);
    wcolClr = 1'b0;
    check(wcol == 1'b0, "R9 wcol cleared by wcolClr", wcol, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    sendByte(8'hA5, 3, 1'b0, 1'b0);
    testIrqClear();
    sendByte(8'h3C, 1, 1'b1, 1'b0);
    testIrqClear();
    sendByte(8'h81, 2, 1'b0, 1'b1);
    testIrqClear();
    sendByte(8'h5A, 4, 1'b0, 1'b0);
    testWcolSticky();
    testIrqClear();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule